// File: doc/BRIEF.md
# Race-Logic Weighted Edit Distance Grid

This block scores the alignment of two fixed-length nucleotide strings without any adder or comparator in the datapath. A grid of (N+1) x (N+1) cells holds one fired flag per cell. A start pulse sets the top-left cell. From there a wavefront of ones spreads right, down and diagonally. Every edge holds the token back by a number of cycles equal to its edit cost. In minimization mode a cell fires on the first arrival (an OR of its inputs). In maximization mode it waits for every incoming edge (an AND). The score is the cycle at which the bottom-right cell fires, counted from the start pulse.

The cells are tiled into square regions. Each region carries an enable that is high only while the wavefront has reached the region and has not yet fired all of its cells. The enables are exported so that a clock-gating wrapper or a power monitor can use them. The controller is a three-state machine:
- `ST_IDLE`: after reset.
- `ST_RUN`: entered on a start pulse from any state, which restarts a run already in progress.
- `ST_DONE`: entered from `ST_RUN` once the last cell has fired. A new start pulse leaves it for `ST_RUN`.

Top module: `race_edit_array`

## Requirements
- R1: After reset, `done` is 0, `score` is 0 and `region_en` is all zeros.
- R2: Symbols are 2 bits, with A=00, C=01, G=10 and T=11. Symbol k of a string occupies bits [2k+1:2k]. `str_a` indexes the columns and `str_b` indexes the rows. A horizontal or vertical step costs 1. A diagonal step costs 1 when its two symbols are equal and 2 when they differ.
- R3: With `mode_max`=0 the score is the minimum path cost from the top-left cell to the bottom-right cell. For example, identical strings give 8, two strings with no common symbol give 16, and 16'h0000 against 16'h4000 gives 9.
- R4: With `mode_max`=1 a cell fires only after all of its incoming edges have delivered. The score is therefore the maximum path cost, which is 2N (16) for any strings.
- R5: Call E0 the clock edge that samples `start`. `done` rises at edge E0+score+1, so the score equals the number of cycles the wavefront needed.
- R6: Once `done` is high, it and `score` hold their values until the next start pulse, whatever the other inputs do.
- R7: `mode_max`, `str_a` and `str_b` are captured on the start edge. Changes to them during a run do not alter the result.
- R8: A start pulse during a run abandons that run. `done` is 0 in the following cycle, and the new run times from the new start edge.
- R9: Regions are 3x3 cell tiles, and region (ri,rj) drives `region_en` bit ri*3+rj. A region's bit is high only while a run is active, the wavefront has reached the region and not all of its cells have fired. One cycle after a start edge the value is 9'b000000001. In `ST_IDLE` and `ST_DONE` it is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Single-cycle run request; it captures the strings and the mode |
| mode_max | input | 1 | 0 = minimize (OR cells), 1 = maximize (AND cells) |
| str_a | input | 2*N | Column string, 2 bits per symbol |
| str_b | input | 2*N | Row string, 2 bits per symbol |
| done | output | 1 | High while the controller is in `ST_DONE` |
| score | output | SW | Cycle count at which the last cell fired |
| region_en | output | NREG | Per-region activity enables |

## Verification
A fired flag that sets too early or too late moves the rise of `done` by the same number of cycles. It also changes `score` in that same cycle, so every run is timed against its start edge as well as valued. A diagonal delay chosen wrongly is visible only when the strings pair mismatched symbols on the winning path. The vectors therefore include shifted strings and disjoint strings. A region enable stuck high or low shows at `region_en` within one cycle of the start edge, and again once the run has finished.

// File: rtl/rl_pkg.sv
package rl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } rl_state_e;

endpackage

// File: rtl/rl_cell.sv
module rl_cell #(
    parameter bit HAS_L  = 1'b0,
    parameter bit HAS_U  = 1'b0,
    parameter bit HAS_D  = 1'b0,
    parameter bit ORIGIN = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    input  logic en,
    input  logic mode_max,
    input  logic arr_l,
    input  logic arr_u,
    input  logic diag_src,
    input  logic match,
    output logic fired
);

    logic dly_q;
    logic diag_arr;
    logic any_in;
    logic all_in;
    logic hit;

    // a match uses the source flag directly (cost 1); a mismatch goes through one more stage (cost 2)
    assign diag_arr = match ? diag_src : dly_q;
    assign any_in   = (HAS_L && arr_l) || (HAS_U && arr_u) || (HAS_D && diag_arr);
    assign all_in   = (!HAS_L || arr_l) && (!HAS_U || arr_u) && (!HAS_D || diag_arr);
    assign hit      = mode_max ? all_in : any_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fired <= 1'b0;
            dly_q <= 1'b0;
        end else if (start) begin
            fired <= ORIGIN;
            dly_q <= 1'b0;
        end else if (run && en) begin
            dly_q <= diag_src;
            if (!fired && hit) begin
                fired <= 1'b1;
            end
        end
    end

    // R5
    cell_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fired && !start) |=> fired);

    // R9
    cell_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fired && !start && !en) |=> !fired);

    // R2
    cell_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fired && !start && !arr_l && !arr_u && !diag_src && !dly_q) |=> !fired);

endmodule

// File: rtl/rl_grid.sv
module rl_grid #(
    parameter int N = 8,
    parameter int R = 3,
    localparam int NC   = N + 1,
    localparam int NRB  = (NC + R - 1) / R,
    localparam int NREG = NRB * NRB
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            run,
    input  logic            mode_max,
    input  logic [2*N-1:0]  a_q,
    input  logic [2*N-1:0]  b_q,
    output logic            last_fired,
    output logic [NREG-1:0] region_en
);

    localparam int NCELL = NC * NC;

    logic [NCELL-1:0] fired;
    logic [NCELL-1:0] pred_any;
    logic [NREG-1:0]  reached;
    logic [NREG-1:0]  all_done;

    for (genvar i = 0; i < NC; i++) begin : g_row
        for (genvar j = 0; j < NC; j++) begin : g_col
            logic l_s;
            logic u_s;
            logic d_s;
            logic m_s;

            if (j > 0) begin : g_l
                assign l_s = fired[i*NC + j - 1];
            end else begin : g_nl
                assign l_s = 1'b0;
            end

            if (i > 0) begin : g_u
                assign u_s = fired[(i-1)*NC + j];
            end else begin : g_nu
                assign u_s = 1'b0;
            end

            if (i > 0 && j > 0) begin : g_d
                assign d_s = fired[(i-1)*NC + j - 1];
                assign m_s = (a_q[2*(j-1) +: 2] == b_q[2*(i-1) +: 2]);
            end else begin : g_nd
                assign d_s = 1'b0;
                assign m_s = 1'b0;
            end

            assign pred_any[i*NC + j] = l_s | u_s | d_s;

            rl_cell #(
                .HAS_L  (j > 0),
                .HAS_U  (i > 0),
                .HAS_D  (i > 0 && j > 0),
                .ORIGIN (i == 0 && j == 0)
            ) cell_i (
                .clk      (clk),
                .rst_n    (rst_n),
                .start    (start),
                .run      (run),
                .en       (region_en[(i/R)*NRB + (j/R)]),
                .mode_max (mode_max),
                .arr_l    (l_s),
                .arr_u    (u_s),
                .diag_src (d_s),
                .match    (m_s),
                .fired    (fired[i*NC + j])
            );
        end
    end

    always_comb begin
        reached  = '0;
        all_done = '1;
        for (int c = 0; c < NCELL; c++) begin
            reached[((c / NC) / R) * NRB + ((c % NC) / R)] =
                reached[((c / NC) / R) * NRB + ((c % NC) / R)] | fired[c] | pred_any[c];
            all_done[((c / NC) / R) * NRB + ((c % NC) / R)] =
                all_done[((c / NC) / R) * NRB + ((c % NC) / R)] & fired[c];
        end
    end

    assign region_en  = {NREG{run}} & reached & ~all_done;
    assign last_fired = fired[NCELL-1];

    // R9
    region_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (region_en == NREG'(1)));

endmodule

// File: rtl/rl_ctrl.sv
module rl_ctrl
    import rl_pkg::*;
#(
    parameter int N = 8,
    localparam int SW = $clog2(2*N + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           mode_in,
    input  logic [2*N-1:0] a_in,
    input  logic [2*N-1:0] b_in,
    input  logic           last_fired,
    output logic           run,
    output logic           mode_q,
    output logic [2*N-1:0] a_q,
    output logic [2*N-1:0] b_q,
    output logic           done,
    output logic [SW-1:0]  score
);

    rl_state_e state;
    rl_state_e nxt;
    logic [SW-1:0] cnt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (start) nxt = ST_RUN;
            ST_RUN: begin
                if (start)           nxt = ST_RUN;
                else if (last_fired) nxt = ST_DONE;
            end
            ST_DONE: if (start) nxt = ST_RUN;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        run  = (state == ST_RUN);
        done = (state == ST_DONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            score  <= '0;
            mode_q <= 1'b0;
            a_q    <= '0;
            b_q    <= '0;
        end else if (start) begin
            cnt    <= '0;
            score  <= '0;
            mode_q <= mode_in;
            a_q    <= a_in;
            b_q    <= b_in;
        end else if (state == ST_RUN) begin
            if (cnt != '1) cnt <= cnt + 1'b1;
            if (last_fired) score <= cnt;
        end
    end

    // R6
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(score)));

    // R3
    score_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (score >= SW'(N) && score <= SW'(2*N)));

    // R5
    done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(last_fired));

    // R8
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !done);

endmodule

// File: rtl/race_edit_array.sv
module race_edit_array #(
    parameter int N = 8,
    parameter int R = 3,
    localparam int SW   = $clog2(2*N + 1),
    localparam int NRB  = (N + R) / R,
    localparam int NREG = NRB * NRB
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            mode_max,
    input  logic [2*N-1:0]  str_a,
    input  logic [2*N-1:0]  str_b,
    output logic            done,
    output logic [SW-1:0]   score,
    output logic [NREG-1:0] region_en
);

    logic           run;
    logic           mode_q;
    logic [2*N-1:0] a_q;
    logic [2*N-1:0] b_q;
    logic           last_fired;

    rl_ctrl #(.N(N)) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .mode_in    (mode_max),
        .a_in       (str_a),
        .b_in       (str_b),
        .last_fired (last_fired),
        .run        (run),
        .mode_q     (mode_q),
        .a_q        (a_q),
        .b_q        (b_q),
        .done       (done),
        .score      (score)
    );

    rl_grid #(.N(N), .R(R)) grid_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .run        (run),
        .mode_max   (mode_q),
        .a_q        (a_q),
        .b_q        (b_q),
        .last_fired (last_fired),
        .region_en  (region_en)
    );

endmodule

// File: tb/race_edit_array_tb_top.sv
module race_edit_array_tb_top;

    localparam int N    = 8;
    localparam int SW   = 5;
    localparam int NREG = 9;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            start;
    logic            mode_max;
    logic [2*N-1:0]  str_a;
    logic [2*N-1:0]  str_b;
    logic            done;
    logic [SW-1:0]   score;
    logic [NREG-1:0] region_en;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    race_edit_array #(.N(N), .R(3)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .mode_max  (mode_max),
        .str_a     (str_a),
        .str_b     (str_b),
        .done      (done),
        .score     (score),
        .region_en (region_en)
    );

    typedef struct packed {
        logic [15:0] a;
        logic [15:0] b;
        logic        mx;
        logic [4:0]  ex;
    } vec_t;

    // 0000 = all A, 5555 = all C, 4000 = AAAAAAAC, E4E4 = ACGTACGT, 3939 = CGTACGTA
    localparam vec_t VEC [6] = '{
        '{16'h0000, 16'h0000, 1'b0, 5'd8},
        '{16'h0000, 16'h0000, 1'b1, 5'd16},
        '{16'h0000, 16'h5555, 1'b0, 5'd16},
        '{16'h0000, 16'h4000, 1'b0, 5'd9},
        '{16'hE4E4, 16'h3939, 1'b0, 5'd9},
        '{16'hE4E4, 16'h3939, 1'b1, 5'd16}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // path-cost reference built from R2 costs; mx selects longest path (R4)
    function automatic int model(input logic [15:0] a, input logic [15:0] b, input bit mx);
        int v [9][9];
        for (int i = 0; i < 9; i++) begin
            for (int j = 0; j < 9; j++) begin
                int best;
                int cand;
                if (i == 0 && j == 0) begin
                    v[i][j] = 0;
                end else begin
                    best = mx ? -1 : 1000;
                    if (j > 0) begin
                        cand = v[i][j-1] + 1;
                        best = mx ? ((cand > best) ? cand : best) : ((cand < best) ? cand : best);
                    end
                    if (i > 0) begin
                        cand = v[i-1][j] + 1;
                        best = mx ? ((cand > best) ? cand : best) : ((cand < best) ? cand : best);
                    end
                    if (i > 0 && j > 0) begin
                        cand = v[i-1][j-1] + ((a[2*(j-1) +: 2] == b[2*(i-1) +: 2]) ? 1 : 2);
                        best = mx ? ((cand > best) ? cand : best) : ((cand < best) ? cand : best);
                    end
                    v[i][j] = best;
                end
            end
        end
        return v[8][8];
    endfunction

    task automatic start_case(input logic [15:0] a, input logic [15:0] b, input bit mx);
        @(negedge clk);
        str_a    = a;
        str_b    = b;
        mode_max = mx;
        start    = 1'b1;
        @(negedge clk);
        start    = 1'b0;
    endtask

    task automatic wait_done(output int k);
        k = 0;
        while (!done && k < 60) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic run_case(input logic [15:0] a, input logic [15:0] b, input bit mx,
                            input int exp, input string req);
        int k;
        start_case(a, b, mx);
        wait_done(k);
        chk(done == 1'b1 && int'(score) == exp, req, int'(score), exp);
        chk(k == exp + 1, "R5 latency", k, exp + 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int k;
        rst_n    = 1'b0;
        start    = 1'b0;
        mode_max = 1'b0;
        str_a    = '0;
        str_b    = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(done == 1'b0, "R1 done", int'(done), 0);
        chk(score == '0, "R1 score", int'(score), 0);
        chk(region_en == '0, "R1 region_en", int'(region_en), 0);

        // vector table: R3 (min) and R4 (max)
        for (int v = 0; v < 6; v++) begin
            run_case(VEC[v].a, VEC[v].b, VEC[v].mx, int'(VEC[v].ex), VEC[v].mx ? "R4 score" : "R3 score");
        end

        // R2 costs against the path model on assorted strings
        run_case(16'hE4E4, 16'h1B1B, 1'b0, model(16'hE4E4, 16'h1B1B, 1'b0), "R2 min");
        run_case(16'hA5F0, 16'h0F5A, 1'b0, model(16'hA5F0, 16'h0F5A, 1'b0), "R2 min");
        run_case(16'h9C63, 16'h36C9, 1'b1, model(16'h9C63, 16'h36C9, 1'b1), "R4 max");

        // R9 region enables at the start and after completion
        start_case(16'h0000, 16'h0000, 1'b0);
        chk(region_en == 9'b000000001, "R9 first cycle", int'(region_en), 1);
        wait_done(k);
        chk(region_en == '0, "R9 after done", int'(region_en), 0);

        // R6 done and score held while inputs wander
        str_a    = 16'hFFFF;
        mode_max = 1'b1;
        repeat (5) @(negedge clk);
        chk(done == 1'b1 && score == 5'd8, "R6 hold", int'(score), 8);

        // R7 inputs changed after the start edge are ignored
        start_case(16'h0000, 16'h4000, 1'b0);
        mode_max = 1'b1;
        str_b    = 16'h0000;
        wait_done(k);
        chk(int'(score) == 9, "R7 captured inputs", int'(score), 9);
        chk(k == 10, "R7 latency", k, 10);

        // R8 restart mid-run
        start_case(16'h0000, 16'h5555, 1'b0);
        repeat (4) @(negedge clk);
        start_case(16'h0000, 16'h0000, 1'b0);
        chk(done == 1'b0, "R8 done cleared", int'(done), 0);
        wait_done(k);
        chk(int'(score) == 8, "R8 restart score", int'(score), 8);
        chk(k == 9, "R8 restart latency", k, 9);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule